// File: doc/BRIEF.md
# Speculative Load Ordering Buffer

The block keeps track of loads that a core has issued ahead of the memory consistency rules, so that a broken ordering can be caught before those loads commit. Each issued load takes one slot in a circular buffer. The slot records the physical address, an acquire flag, a performed flag and an optional store tag. A store tag names an older store that the load must wait behind. Loads leave the buffer in issue order from the oldest slot, and only when their ordering conditions are met.

Coherence traffic reaches the block on a single snoop port. Invalidations, ownership requests, updates and replacements all use this port and are handled the same way. The snoop address is compared with every live slot in parallel. A hit means the value that was read speculatively may be stale. The block then reports the oldest matching slot, and the core's restart logic flushes that slot and every younger one through the flush port.

The depth must be a power of two.

Top module: `spec_load_buf`

## Requirements
- R1: While reset is held, and right after it, the outputs are as follows: `empty_o` is 1, `full_o` is 0, `retire_valid_o` is 0, `viol_valid_o` is 0 and `alloc_idx_o` is 0.
- R2: A load is accepted when `alloc_valid_i` and `alloc_ready_o` are both high on a clock edge. It takes the slot shown on `alloc_idx_o`. Slots are handed out in ascending order, wrapping modulo DEPTH. `alloc_ready_o` is low while the buffer is full.
- R3: Slots leave only from the oldest end and in allocation order. `retire_valid_o` is combinational. When it is high, `retire_addr_o` shows the oldest slot's address, and that slot is removed at the same clock edge.
- R4: Store tag value 0 means the load has no store dependency. The oldest slot cannot retire while its tag is nonzero. A store completion frees every live slot that carries the completing tag, and the effect is visible from the next cycle. If a load is allocated in the same cycle as the completion of the store it names, it is stored with a null tag.
- R5: A slot with its acquire flag set cannot retire until a performed report (`done_valid_i` with its index) has been taken at an earlier edge. A slot without the acquire flag ignores the performed flag.
- R6: While `sc_mode_i` is high, every load allocated is marked as an acquire, whatever `alloc_acq_i` says.
- R7: A snoop that hits one or more live slots raises `viol_valid_o` for exactly one cycle, one clock after the snoop. In that cycle `viol_idx_o` gives the matching slot nearest the oldest end. A slot that retires or is flushed in the snoop cycle is not matched.
- R8: A flush naming a live slot removes that slot and all younger ones at the next edge. The next allocation then reuses the flushed index. A flush naming a slot that is not live has no effect. `alloc_ready_o` is low during any cycle in which `flush_valid_i` is high. If the flush names the oldest slot, that slot does not retire.
- R9: `full_o` is high exactly when DEPTH slots are live, and `empty_o` is high exactly when none are. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sc_mode_i | input | 1 | Treat every new load as an acquire |
| alloc_valid_i | input | 1 | Load allocation request |
| alloc_addr_i | input | ADDR_W | Physical address of the load |
| alloc_acq_i | input | 1 | Load is an acquire |
| alloc_tag_i | input | TAG_W | Older store the load waits on (0 = none) |
| alloc_ready_o | output | 1 | Allocation accepted this cycle |
| alloc_idx_o | output | IDX_W | Slot the next accepted load takes |
| done_valid_i | input | 1 | A load has been performed |
| done_idx_i | input | IDX_W | Slot of the performed load |
| st_done_valid_i | input | 1 | A store has completed |
| st_done_tag_i | input | TAG_W | Tag of the completed store |
| snoop_valid_i | input | 1 | Coherence event present |
| snoop_addr_i | input | ADDR_W | Address of the coherence event |
| flush_valid_i | input | 1 | Flush request |
| flush_idx_i | input | IDX_W | Oldest slot to flush |
| retire_valid_o | output | 1 | Oldest slot retires at this edge |
| retire_addr_o | output | ADDR_W | Address of the retiring load |
| viol_valid_o | output | 1 | Misspeculation detected |
| viol_idx_o | output | IDX_W | Oldest slot hit by the snoop |
| full_o | output | 1 | All slots live |
| empty_o | output | 1 | No slot live |

## Verification
The outputs fall into three timing groups:

- `retire_valid_o`, `retire_addr_o` and `alloc_ready_o` are due in the same cycle as the stimulus. They are combinational in the stored state and the present flush request.
- `viol_valid_o` and `viol_idx_o` are due one edge after the snoop.
- `full_o`, `empty_o`, `alloc_idx_o` and the effects of store completion, performed reports and flushes are due one edge after the request.

The bench drives each cycle's inputs on the falling edge. It lets them settle, then compares every output against a queue-based model. That model has already absorbed the preceding rising edge, so combinational results are checked against the current inputs and registered results against the previous edge, without any extra delay in between.

// File: rtl/slob_pkg.sv
package slob_pkg;
  localparam int unsigned NULL_TAG = 0;

  // distance of a slot from the oldest slot in a ring of depth entries
  function automatic int unsigned slot_age(int unsigned slot, int unsigned head,
                                           int unsigned depth);
    return (slot + depth - head) % depth;
  endfunction
endpackage

// File: rtl/slob_entry.sv
module slob_entry #(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              wr_acq_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic              drop_i,
  input  logic              done_i,
  input  logic              st_v_i,
  input  logic [TAG_W-1:0]  st_tag_i,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              acq_o,
  output logic              done_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic              hit_o
);
  logic              valid_q, acq_q, done_q;
  logic [ADDR_W-1:0] addr_q;
  logic [TAG_W-1:0]  tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      acq_q   <= 1'b0;
      done_q  <= 1'b0;
      tag_q   <= '0;
    end else if (drop_i) begin
      valid_q <= 1'b0;
    end else if (wr_i) begin
      valid_q <= 1'b1;
      addr_q  <= wr_addr_i;
      acq_q   <= wr_acq_i;
      done_q  <= 1'b0;
      // store finishing in the allocation cycle frees the new load at once
      tag_q   <= (st_v_i && st_tag_i == wr_tag_i) ? TAG_W'(slob_pkg::NULL_TAG) : wr_tag_i;
    end else if (valid_q) begin
      if (done_i) done_q <= 1'b1;
      if (st_v_i && tag_q == st_tag_i) tag_q <= TAG_W'(slob_pkg::NULL_TAG);
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign acq_o   = acq_q;
  assign done_o  = done_q;
  assign tag_o   = tag_q;
  assign hit_o   = valid_q && (addr_q == snoop_addr_i);
endmodule

// File: rtl/slob_oldest_pick.sv
module slob_oldest_pick #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic [DEPTH-1:0] cand_i,
  input  logic [IDX_W-1:0] head_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] slot;

  // scan youngest to oldest so the oldest hit wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    slot    = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      slot = head_i + IDX_W'(k);
      if (cand_i[slot]) begin
        found_o = 1'b1;
        idx_o   = slot;
      end
    end
  end
endmodule

// File: rtl/spec_load_buf.sv
module spec_load_buf #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 3,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sc_mode_i,
  input  logic              alloc_valid_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  input  logic              alloc_acq_i,
  input  logic [TAG_W-1:0]  alloc_tag_i,
  output logic              alloc_ready_o,
  output logic [IDX_W-1:0]  alloc_idx_o,
  input  logic              done_valid_i,
  input  logic [IDX_W-1:0]  done_idx_i,
  input  logic              st_done_valid_i,
  input  logic [TAG_W-1:0]  st_done_tag_i,
  input  logic              snoop_valid_i,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  input  logic              flush_valid_i,
  input  logic [IDX_W-1:0]  flush_idx_i,
  output logic              retire_valid_o,
  output logic [ADDR_W-1:0] retire_addr_o,
  output logic              viol_valid_o,
  output logic [IDX_W-1:0]  viol_idx_o,
  output logic              full_o,
  output logic              empty_o
);
  localparam int CNT_W = IDX_W + 1;

  logic [IDX_W-1:0]  head_q, tail_q;
  logic [CNT_W-1:0]  count_q;
  logic [DEPTH-1:0]  ent_valid, ent_acq, ent_done, ent_hit;
  logic [DEPTH-1:0]  ent_wr, ent_drop, ent_cand;
  logic [ADDR_W-1:0] ent_addr [DEPTH];
  logic [TAG_W-1:0]  ent_tag  [DEPTH];
  logic              alloc_fire, flush_ok, head_ok, retire_fire, pick_found;
  logic [IDX_W-1:0]  flush_age, pick_idx;
  logic              viol_q;
  logic [IDX_W-1:0]  viol_idx_q;

  assign full_o        = (count_q == CNT_W'(DEPTH));
  assign empty_o       = (count_q == '0);
  assign alloc_ready_o = !full_o && !flush_valid_i;
  assign alloc_idx_o   = tail_q;
  assign alloc_fire    = alloc_valid_i && alloc_ready_o;

  assign flush_ok  = flush_valid_i && ent_valid[flush_idx_i];
  assign flush_age = IDX_W'(slob_pkg::slot_age(32'(flush_idx_i), 32'(head_q), DEPTH));

  assign head_ok = ent_valid[head_q] && (ent_tag[head_q] == TAG_W'(slob_pkg::NULL_TAG)) &&
                   (!ent_acq[head_q] || ent_done[head_q]);
  assign retire_fire    = head_ok && !(flush_ok && flush_idx_i == head_q);
  assign retire_valid_o = retire_fire;
  assign retire_addr_o  = ent_addr[head_q];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [IDX_W-1:0] age;
    logic             kill, pop;
    assign age         = IDX_W'(slob_pkg::slot_age(i, 32'(head_q), DEPTH));
    assign kill        = flush_ok && (age >= flush_age);
    assign pop         = retire_fire && (head_q == IDX_W'(i));
    assign ent_drop[i] = kill || pop;
    assign ent_wr[i]   = alloc_fire && (tail_q == IDX_W'(i));
    assign ent_cand[i] = snoop_valid_i && ent_hit[i] && !ent_drop[i];

    slob_entry #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) i_entry (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .wr_i         (ent_wr[i]),
      .wr_addr_i    (alloc_addr_i),
      .wr_acq_i     (alloc_acq_i || sc_mode_i),
      .wr_tag_i     (alloc_tag_i),
      .drop_i       (ent_drop[i]),
      .done_i       (done_valid_i && done_idx_i == IDX_W'(i)),
      .st_v_i       (st_done_valid_i),
      .st_tag_i     (st_done_tag_i),
      .snoop_addr_i (snoop_addr_i),
      .valid_o      (ent_valid[i]),
      .addr_o       (ent_addr[i]),
      .acq_o        (ent_acq[i]),
      .done_o       (ent_done[i]),
      .tag_o        (ent_tag[i]),
      .hit_o        (ent_hit[i])
    );
  end

  slob_oldest_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_pick (
    .cand_i  (ent_cand),
    .head_i  (head_q),
    .found_o (pick_found),
    .idx_o   (pick_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q     <= '0;
      tail_q     <= '0;
      count_q    <= '0;
      viol_q     <= 1'b0;
      viol_idx_q <= '0;
    end else begin
      viol_q     <= pick_found;
      viol_idx_q <= pick_idx;
      head_q     <= head_q + IDX_W'(retire_fire);
      if (flush_ok) begin
        tail_q  <= flush_idx_i;
        count_q <= {1'b0, flush_age} - CNT_W'(retire_fire);
      end else begin
        tail_q  <= tail_q + IDX_W'(alloc_fire);
        count_q <= count_q + CNT_W'(alloc_fire) - CNT_W'(retire_fire);
      end
    end
  end

  assign viol_valid_o = viol_q;
  assign viol_idx_o   = viol_idx_q;
endmodule

// File: rtl/spec_load_buf_chk.sv
module spec_load_buf_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             alloc_valid_i,
  input logic             alloc_ready_o,
  input logic             flush_valid_i,
  input logic             snoop_valid_i,
  input logic             retire_valid_o,
  input logic             viol_valid_o,
  input logic [IDX_W-1:0] viol_idx_o,
  input logic             full_o,
  input logic             empty_o
);
  p_full_blocks_alloc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !alloc_ready_o);

  p_retire_needs_entry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_valid_o |-> !empty_o);

  p_viol_follows_snoop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_valid_o |-> $past(snoop_valid_i));

  p_flush_blocks_alloc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_valid_i |-> !alloc_ready_o);

  p_flags_exclusive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  p_alloc_not_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_valid_i && alloc_ready_o) |=> !empty_o);

  p_viol_idx_known_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_valid_o |-> !$isunknown(viol_idx_o));
endmodule

bind spec_load_buf spec_load_buf_chk #(.IDX_W(IDX_W)) i_spec_load_buf_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .alloc_valid_i  (alloc_valid_i),
  .alloc_ready_o  (alloc_ready_o),
  .flush_valid_i  (flush_valid_i),
  .snoop_valid_i  (snoop_valid_i),
  .retire_valid_o (retire_valid_o),
  .viol_valid_o   (viol_valid_o),
  .viol_idx_o     (viol_idx_o),
  .full_o         (full_o),
  .empty_o        (empty_o)
);

// File: tb/test_spec_load_buf.sv
module test_spec_load_buf;
  localparam int DEPTH  = 8;
  localparam int ADDR_W = 32;
  localparam int TAG_W  = 3;
  localparam int IDX_W  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              sc_mode = 0, al_v = 0, al_acq = 0, dn_v = 0, st_v = 0, sn_v = 0, fl_v = 0;
  logic [ADDR_W-1:0] al_addr = 0, sn_addr = 0;
  logic [TAG_W-1:0]  al_tag = 0, st_tag = 0;
  logic [IDX_W-1:0]  dn_idx = 0, fl_idx = 0;
  logic              alloc_ready, retire_valid, viol_valid, full, empty;
  logic [IDX_W-1:0]  alloc_idx, viol_idx;
  logic [ADDR_W-1:0] retire_addr;

  spec_load_buf #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) i_spec_load_buf (
    .clk_i(clk), .rst_ni(rst_n), .sc_mode_i(sc_mode),
    .alloc_valid_i(al_v), .alloc_addr_i(al_addr), .alloc_acq_i(al_acq), .alloc_tag_i(al_tag),
    .alloc_ready_o(alloc_ready), .alloc_idx_o(alloc_idx),
    .done_valid_i(dn_v), .done_idx_i(dn_idx),
    .st_done_valid_i(st_v), .st_done_tag_i(st_tag),
    .snoop_valid_i(sn_v), .snoop_addr_i(sn_addr),
    .flush_valid_i(fl_v), .flush_idx_i(fl_idx),
    .retire_valid_o(retire_valid), .retire_addr_o(retire_addr),
    .viol_valid_o(viol_valid), .viol_idx_o(viol_idx),
    .full_o(full), .empty_o(empty)
  );

  typedef struct {
    int        idx;
    bit [31:0] addr;
    bit        acq;
    bit        done;
    int        tag;
  } ent_t;

  ent_t q[$];
  int   m_tail = 0;
  bit   m_viol = 0;
  int   m_viol_idx = 0;
  int   n_tests = 0, n_fail = 0, cycles = 0;

  function automatic bit head_ready();
    return q.size() > 0 && q[0].tag == 0 && (!q[0].acq || q[0].done);
  endfunction

  function automatic int flush_pos();
    if (!fl_v) return -1;
    foreach (q[j]) if (q[j].idx == int'(fl_idx)) return j;
    return -1;
  endfunction

  task automatic model_step();
    int  fpos = flush_pos();
    bit  ret  = head_ready() && fpos != 0;
    bit  af   = al_v && q.size() < DEPTH && !fl_v;
    m_viol = 0;
    if (sn_v) begin
      for (int j = 0; j < q.size(); j++) begin
        if (j == 0 && ret) continue;
        if (fpos >= 0 && j >= fpos) continue;
        if (q[j].addr == sn_addr) begin
          m_viol = 1; m_viol_idx = q[j].idx; break;
        end
      end
    end
    if (dn_v) foreach (q[j]) if (q[j].idx == int'(dn_idx)) q[j].done = 1;
    if (st_v) foreach (q[j]) if (q[j].tag == int'(st_tag)) q[j].tag = 0;
    if (fpos >= 0) begin
      while (q.size() > fpos) void'(q.pop_back());
      m_tail = int'(fl_idx);
    end
    if (ret) void'(q.pop_front());
    if (af) begin
      ent_t e;
      e.idx = m_tail; e.addr = al_addr; e.acq = al_acq || sc_mode; e.done = 0;
      e.tag = (st_v && st_tag == al_tag) ? 0 : int'(al_tag);
      q.push_back(e);
      m_tail = (m_tail + 1) % DEPTH;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      q.delete(); m_tail = 0; m_viol = 0; m_viol_idx = 0;
    end else model_step();
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(string req, string what, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare();
    bit rv = head_ready() && flush_pos() != 0;
    check("R9", "empty_o", empty, q.size() == 0);
    check("R9", "full_o", full, q.size() == DEPTH);
    check("R2", "alloc_ready_o", alloc_ready, q.size() < DEPTH && !fl_v);
    check("R2 R8", "alloc_idx_o", alloc_idx, m_tail);
    check("R3 R4 R5 R6", "retire_valid_o", retire_valid, rv);
    if (rv) check("R3", "retire_addr_o", retire_addr, q[0].addr);
    check("R7", "viol_valid_o", viol_valid, m_viol);
    if (m_viol) check("R7", "viol_idx_o", viol_idx, m_viol_idx);
  endtask

  // compare with current inputs, then advance one clock and clear strobes
  task automatic tick();
    #1 compare();
    @(negedge clk);
    al_v = 0; dn_v = 0; st_v = 0; sn_v = 0; fl_v = 0; al_acq = 0; al_tag = 0;
  endtask

  task automatic alloc(int addr, int tag, bit acq);
    al_v = 1; al_addr = addr; al_tag = TAG_W'(tag); al_acq = acq;
    tick();
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "empty_o", empty, 1);
    check("R1", "full_o", full, 0);
    check("R1", "retire_valid_o", retire_valid, 0);
    check("R1", "viol_valid_o", viol_valid, 0);
    check("R1", "alloc_idx_o", alloc_idx, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 R9: fill behind tag 1, overflow attempt, then release (R4)
    for (int k = 0; k < DEPTH; k++) alloc('h100 + k, 1, 0);
    alloc('h1ff, 1, 0);
    st_v = 1; st_tag = 1; tick();
    idle(DEPTH + 2);

    // R4: wrong tag has no effect, right tag frees; alloc during completion
    alloc('h200, 2, 0);
    alloc('h204, 0, 0);
    idle(2);
    st_v = 1; st_tag = 3; tick();
    idle(2);
    st_v = 1; st_tag = 2; al_v = 1; al_addr = 'h208; al_tag = 2; tick();
    idle(3);

    // R5: acquire waits for performed report
    alloc('h300, 0, 1);
    idle(2);
    dn_v = 1; dn_idx = alloc_idx - 1; tick();
    idle(2);

    // R6: sc mode forces acquire
    sc_mode = 1;
    alloc('h400, 0, 0);
    idle(2);
    dn_v = 1; dn_idx = alloc_idx - 1; tick();
    idle(2);
    sc_mode = 0;

    // R7: multiple matches report the oldest
    alloc('h500, 5, 0);
    alloc('h504, 5, 0);
    alloc('h500, 5, 0);
    alloc('h508, 5, 0);
    sn_v = 1; sn_addr = 'h500; tick();
    idle(1);
    sn_v = 1; sn_addr = 'h50c; tick();
    idle(1);
    sn_v = 1; sn_addr = 'h504; tick();
    idle(1);

    // R8: flush the second load, invalid flush, flush at head
    fl_v = 1; fl_idx = alloc_idx - 3; tick();
    idle(1);
    fl_v = 1; fl_idx = alloc_idx + 2; tick();
    idle(1);
    fl_v = 1; fl_idx = alloc_idx - 1; tick();
    idle(1);
    st_v = 1; st_tag = 5; tick();
    idle(3);

    // mixed random traffic
    for (int c = 0; c < 4000; c++) begin
      al_v    = ($urandom % 100) < 45;
      al_addr = 'h600 + 4 * ($urandom % 5);
      al_tag  = TAG_W'($urandom % 4);
      al_acq  = ($urandom % 3) == 0;
      sc_mode = (c / 500) % 2 == 1;
      dn_v    = ($urandom % 100) < 40;
      dn_idx  = IDX_W'($urandom);
      st_v    = ($urandom % 100) < 25;
      st_tag  = TAG_W'(1 + $urandom % 3);
      sn_v    = ($urandom % 100) < 20;
      sn_addr = 'h600 + 4 * ($urandom % 6);
      fl_v    = ($urandom % 100) < 4;
      fl_idx  = IDX_W'($urandom);
      tick();
    end
    sc_mode = 0;
    idle(2);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule